// File: doc/BRIEF.md
# Vertex Attribute Fetch Sequencer

For every vertex this block turns a packed 64-bit attribute descriptor into a stream of memory byte addresses, one for each component of each enabled attribute. Each address leaves on a valid/ready channel. The channel also carries the attribute number, the component number, the element format and the element width in bytes. A downstream fetch unit can then read and convert the data without decoding the descriptor again.

Some attributes are marked as default: either their mask bit is set, or their index lies beyond the twelve attributes that have descriptor fields. No address is produced for a default attribute. Instead, a one-cycle select pulse tells the consumer to use its stored default vector for that attribute number.

Attributes that share one interleaved buffer can be chained. The start address of a chained attribute is the start address of the previous attribute plus that attribute's packed size. Once the last attribute has been issued, a done pulse closes the vertex.

Top module: `vaf_fetch_seq`

## Requirements
- R1: Attribute n (0..11) takes its format from descriptor bits [4n+1:4n] and its component count minus one from bits [4n+3:4n+2]. Components 0..count-1 are issued, and `av_fmt_o` reports the format as 0 = signed byte, 1 = unsigned byte, 2 = signed 16-bit, 3 = 32-bit float.
- R2: `av_esize_o` is 4 for the float format, 2 for the 16-bit format and 1 for both byte formats.
- R3: The vertex covers attributes 0 to descriptor[63:60] inclusive. They are taken in ascending attribute order, and within each attribute the components are taken in ascending order.
- R4: An attribute is a default attribute when its index is 12 or more, or when descriptor bit 48+index is set. For such an attribute no address is issued. `dflt_valid_o` is high for exactly one cycle, with `dflt_attr_o` set to its index.
- R5: The component address is effective base + stride × vertex index + component × element size, taken modulo 2^ADDR_W. The effective base is the attribute's own `base_i` slot (attribute k occupies bits [32k+31:32k]), and the stride comes from the same slot of `stride_i`.
- R6: When `pack_i[n]` is set for 1 ≤ n ≤ 11, the effective base of attribute n is the effective base of attribute n-1 plus that attribute's component count × element size. This holds even when attribute n-1 is a default attribute. `pack_i[0]` has no effect.
- R7: While `av_valid_o` is high and `av_ready_i` is low, the valid flag, address, attribute, component and format are all held unchanged into the next cycle.
- R8: `done_o` is high for exactly one cycle: the cycle after the final address transfer or the final default pulse of the vertex.
- R9: A start pulse that arrives while a vertex is in progress, including the done cycle, is ignored. The stream of the running vertex is unchanged, and no further vertex begins.
- R10: After reset `av_valid_o`, `dflt_valid_o` and `done_o` are low until a start pulse arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a vertex; vertex index and descriptor are captured |
| vtx_idx_i | input | IDX_W | Vertex index |
| desc_i | input | 64 | Packed attribute descriptor |
| pack_i | input | 12 | Per-attribute chaining enable |
| base_i | input | NUM_ATTR*ADDR_W | Per-attribute base address, attribute k in slot k |
| stride_i | input | NUM_ATTR*ADDR_W | Per-attribute stride, attribute k in slot k |
| av_valid_o | output | 1 | Address item valid |
| av_ready_i | input | 1 | Consumer accepts the address item |
| av_addr_o | output | ADDR_W | Component byte address |
| av_attr_o | output | AW | Attribute index of the item |
| av_comp_o | output | 2 | Component index of the item |
| av_fmt_o | output | 2 | Element format code |
| av_esize_o | output | 3 | Element size in bytes |
| dflt_valid_o | output | 1 | Use stored default for an attribute |
| dflt_attr_o | output | AW | Attribute index taking the default |
| done_o | output | 1 | Vertex finished |

## Verification
Two events can fall in the same cycle. One is the done pulse of a vertex. The other is a fresh start request from the host, which may also land in any earlier cycle of a vertex that is still running.

The bench raises start in the middle of a vertex, using a different vertex index and descriptor. It raises start again in exactly the cycle where done is seen.

The scoreboard judges both cases. The running vertex must deliver exactly its predicted items and a single done. After that, several idle cycles must pass with no address, default or done activity at all.

// File: rtl/vaf_pkg.sv
package vaf_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // element format codes carried on the address stream
  typedef enum logic [1:0] {
    FMT_S8  = 2'd0,
    FMT_U8  = 2'd1,
    FMT_S16 = 2'd2,
    FMT_F32 = 2'd3
  } vaf_fmt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } vaf_state_e;

  localparam int unsigned DESC_W     = 64;
  localparam int unsigned DESC_ATTRS = 12;
  localparam int unsigned FIELD_W    = 4;
  localparam int unsigned MASK_LSB   = 48;
  localparam int unsigned CNT_LSB    = 60;
  localparam int unsigned CNT_W      = 4;

  function automatic logic [2:0] elem_bytes(input vaf_fmt_e f);
    case (f)
      FMT_F32: return 3'd4;
      FMT_S16: return 3'd2;
      default: return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/vaf_desc_decode.sv
module vaf_desc_decode
  import vaf_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic [DESC_W-1:0] desc_i,
  input  logic [AW-1:0]     attr_i,
  output vaf_fmt_e          fmt_o,
  output logic [1:0]        ncomp_m1_o,
  output logic [2:0]        esize_o,
  output logic [4:0]        bytes_o,
  output logic              is_dflt_o,
  output logic [AW-1:0]     last_attr_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [1:0]            fmt_a [DESC_ATTRS];
  logic [1:0]            cnt_a [DESC_ATTRS];
  logic [DESC_ATTRS-1:0] mask;

  for (genvar g = 0; g < DESC_ATTRS; g++) begin : g_field
    assign fmt_a[g] = desc_i[FIELD_W*g +: 2];
    assign cnt_a[g] = desc_i[FIELD_W*g+2 +: 2];
  end

  assign mask        = desc_i[MASK_LSB +: DESC_ATTRS];
  assign last_attr_o = AW'(desc_i[CNT_LSB +: CNT_W]);

  always_comb begin
    fmt_o      = FMT_S8;
    ncomp_m1_o = 2'd0;
    is_dflt_o  = 1'b1;
    if (attr_i < AW'(DESC_ATTRS)) begin
      fmt_o      = vaf_fmt_e'(fmt_a[attr_i]);
      ncomp_m1_o = cnt_a[attr_i];
      is_dflt_o  = mask[attr_i];
    end
  end

  assign esize_o = elem_bytes(fmt_o);
  assign bytes_o = ({3'b000, ncomp_m1_o} + 5'd1) * {2'b00, esize_o};
endmodule

// File: rtl/vaf_addr_gen.sv
module vaf_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [IDX_W-1:0]  vtx_i,
  input  logic [1:0]        comp_i,
  input  logic [2:0]        esize_i,
  output logic [ADDR_W-1:0] addr_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned PROD_W = ADDR_W + IDX_W;

  logic [PROD_W-1:0] vtx_off;
  logic [4:0]        comp_off;

  assign vtx_off  = PROD_W'(stride_i) * PROD_W'(vtx_i);
  assign comp_off = {3'b000, comp_i} * {2'b00, esize_i};
  assign addr_o   = base_i + vtx_off[ADDR_W-1:0] + ADDR_W'(comp_off);
endmodule

// File: rtl/vaf_seq_ctrl.sv
module vaf_seq_ctrl
  import vaf_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 16,
  parameter int unsigned AW     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  vtx_i,
  input  logic [DESC_W-1:0] desc_i,
  input  logic [ADDR_W-1:0] base0_i,
  input  logic [ADDR_W-1:0] next_base_i,
  input  logic              ready_i,
  input  logic              is_dflt_i,
  input  logic [1:0]        ncomp_m1_i,
  input  logic [AW-1:0]     last_attr_i,
  output logic [DESC_W-1:0] desc_o,
  output logic [IDX_W-1:0]  vtx_o,
  output logic [AW-1:0]     attr_o,
  output logic [1:0]        comp_o,
  output logic [ADDR_W-1:0] base_o,
  output logic              run_o,
  output logic              fin_o
);
  timeunit 1ns;
  timeprecision 1ps;

  vaf_state_e        state_q, state_d;
  logic [AW-1:0]     attr_q, attr_d;
  logic [1:0]        comp_q, comp_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [DESC_W-1:0] desc_q;
  logic [IDX_W-1:0]  vtx_q;
  logic              load_en;
  logic              step;

  assign load_en = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    attr_d  = attr_q;
    comp_d  = comp_q;
    base_d  = base_q;
    step    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_RUN;
          attr_d  = '0;
          comp_d  = 2'd0;
          base_d  = base0_i;
        end
      end
      ST_RUN: begin
        if (is_dflt_i) begin
          step = 1'b1;
        end else if (ready_i) begin
          if (comp_q == ncomp_m1_i) step = 1'b1;
          else comp_d = comp_q + 2'd1;
        end
        if (step) begin
          comp_d = 2'd0;
          if (attr_q == last_attr_i) begin
            state_d = ST_FIN;
          end else begin
            attr_d = attr_q + 1'b1;
            base_d = next_base_i;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      attr_q  <= '0;
      comp_q  <= 2'd0;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      attr_q  <= attr_d;
      comp_q  <= comp_d;
      base_q  <= base_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      desc_q <= '0;
      vtx_q  <= '0;
    end else if (load_en) begin
      desc_q <= desc_i;
      vtx_q  <= vtx_i;
    end
  end

  assign desc_o = desc_q;
  assign vtx_o  = vtx_q;
  assign attr_o = attr_q;
  assign comp_o = comp_q;
  assign base_o = base_q;
  assign run_o  = (state_q == ST_RUN);
  assign fin_o  = (state_q == ST_FIN);

  // R9: a request while busy must not disturb the captured vertex
  assert_busy_start_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) && start_i |=> $stable(vtx_q) && $stable(desc_q));

  // R3: the attribute number only stays or climbs by one while running
  assert_attr_step_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |=> (state_q != ST_RUN) || (attr_q == $past(attr_q))
                            || (attr_q == $past(attr_q) + 1'b1));

  // R8: done is a single-cycle pulse
  assert_done_pulse_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |=> !fin_o);
endmodule

// File: rtl/vaf_fetch_seq.sv
module vaf_fetch_seq
  import vaf_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned IDX_W    = 16,
  parameter int unsigned NUM_ATTR = 16,
  localparam int unsigned AW      = $clog2(NUM_ATTR)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [IDX_W-1:0]           vtx_idx_i,
  input  logic [63:0]                desc_i,
  input  logic [11:0]                pack_i,
  input  logic [NUM_ATTR*ADDR_W-1:0] base_i,
  input  logic [NUM_ATTR*ADDR_W-1:0] stride_i,
  output logic                       av_valid_o,
  input  logic                       av_ready_i,
  output logic [ADDR_W-1:0]          av_addr_o,
  output logic [AW-1:0]              av_attr_o,
  output logic [1:0]                 av_comp_o,
  output logic [1:0]                 av_fmt_o,
  output logic [2:0]                 av_esize_o,
  output logic                       dflt_valid_o,
  output logic [AW-1:0]              dflt_attr_o,
  output logic                       done_o
);
  timeunit 1ns;
  timeprecision 1ps;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_int = rsync_q[1];

  // per-attribute operand slots
  logic [ADDR_W-1:0] base_a   [NUM_ATTR];
  logic [ADDR_W-1:0] stride_a [NUM_ATTR];

  for (genvar g = 0; g < NUM_ATTR; g++) begin : g_slot
    assign base_a[g]   = base_i[g*ADDR_W +: ADDR_W];
    assign stride_a[g] = stride_i[g*ADDR_W +: ADDR_W];
  end

  logic [DESC_W-1:0] desc_q;
  logic [IDX_W-1:0]  vtx_q;
  logic [AW-1:0]     attr_q;
  logic [1:0]        comp_q;
  logic [ADDR_W-1:0] cur_base;
  logic [ADDR_W-1:0] next_base;
  logic              run, fin;
  vaf_fmt_e          dec_fmt;
  logic [1:0]        dec_ncomp_m1;
  logic [2:0]        dec_esize;
  logic [4:0]        dec_bytes;
  logic              dec_dflt;
  logic [AW-1:0]     dec_last;
  logic [AW-1:0]     nxt_attr;
  logic              chain_sel;

  vaf_seq_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .AW(AW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .start_i     (start_i),
    .vtx_i       (vtx_idx_i),
    .desc_i      (desc_i),
    .base0_i     (base_a[0]),
    .next_base_i (next_base),
    .ready_i     (av_ready_i),
    .is_dflt_i   (dec_dflt),
    .ncomp_m1_i  (dec_ncomp_m1),
    .last_attr_i (dec_last),
    .desc_o      (desc_q),
    .vtx_o       (vtx_q),
    .attr_o      (attr_q),
    .comp_o      (comp_q),
    .base_o      (cur_base),
    .run_o       (run),
    .fin_o       (fin)
  );

  vaf_desc_decode #(.AW(AW)) u_dec (
    .desc_i      (desc_q),
    .attr_i      (attr_q),
    .fmt_o       (dec_fmt),
    .ncomp_m1_o  (dec_ncomp_m1),
    .esize_o     (dec_esize),
    .bytes_o     (dec_bytes),
    .is_dflt_o   (dec_dflt),
    .last_attr_o (dec_last)
  );

  // start address of the following attribute: chained or own slot
  assign nxt_attr = attr_q + 1'b1;

  always_comb begin
    chain_sel = 1'b0;
    if ((nxt_attr != '0) && (nxt_attr < AW'(DESC_ATTRS))) chain_sel = pack_i[nxt_attr];
    next_base = chain_sel ? (cur_base + ADDR_W'(dec_bytes)) : base_a[nxt_attr];
  end

  vaf_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
    .base_i   (cur_base),
    .stride_i (stride_a[attr_q]),
    .vtx_i    (vtx_q),
    .comp_i   (comp_q),
    .esize_i  (dec_esize),
    .addr_o   (av_addr_o)
  );

  assign av_valid_o   = run && !dec_dflt;
  assign av_attr_o    = attr_q;
  assign av_comp_o    = comp_q;
  assign av_fmt_o     = dec_fmt;
  assign av_esize_o   = dec_esize;
  assign dflt_valid_o = run && dec_dflt;
  assign dflt_attr_o  = attr_q;
  assign done_o       = fin;

  // R7: a stalled item stays put
  assert_hold_stable_R7 : assert property (@(posedge clk_i) disable iff (!rst_n_int)
    av_valid_o && !av_ready_i |=> av_valid_o && $stable(av_addr_o) && $stable(av_attr_o)
                                  && $stable(av_comp_o) && $stable(av_fmt_o));

  // R1: the component index never passes the decoded count
  assert_comp_bound_R1 : assert property (@(posedge clk_i) disable iff (!rst_n_int)
    av_valid_o |-> av_comp_o <= dec_ncomp_m1);

  // R4: a default pulse lasts one cycle per attribute, then moves on
  assert_dflt_advance_R4 : assert property (@(posedge clk_i) disable iff (!rst_n_int)
    dflt_valid_o |=> !dflt_valid_o || (dflt_attr_o == $past(dflt_attr_o) + 1'b1));

  // R10: nothing is produced while held in reset state
  assert_quiet_reset_R10 : assert property (@(posedge clk_i)
    !rst_n_int |-> !av_valid_o && !dflt_valid_o && !done_o);
endmodule

// File: tb/test_vaf_fetch_seq.sv
module test_vaf_fetch_seq;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int ADDR_W = 32;
  localparam int IDX_W  = 16;
  localparam int NA     = 16;

  typedef struct {
    int          kind;   // 0 address, 1 default, 2 done
    int          attr;
    int          comp;
    int          fmt;
    int          es;
    logic [31:0] addr;
    bit          chained;
  } item_t;

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic                   start;
  logic [IDX_W-1:0]       vtx;
  logic [63:0]            desc;
  logic [11:0]            pack;
  logic [NA*ADDR_W-1:0]   base_v;
  logic [NA*ADDR_W-1:0]   stride_v;
  logic                   av_valid, av_ready;
  logic [ADDR_W-1:0]      av_addr;
  logic [3:0]             av_attr;
  logic [1:0]             av_comp, av_fmt;
  logic [2:0]             av_esize;
  logic                   dflt_valid;
  logic [3:0]             dflt_attr;
  logic                   done;

  int    n_chk = 0;
  int    n_fail = 0;
  int    unexp = 0;
  bit    mon_en = 1'b0;
  bit    rnd_ready = 1'b0;
  bit    finished = 1'b0;
  item_t q[$];

  bit          stall_prev = 1'b0;
  bit          item_prev = 1'b0;
  logic [31:0] p_addr;
  logic [3:0]  p_attr;
  logic [1:0]  p_comp;

  always #2.5 clk = ~clk;

  vaf_fetch_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .NUM_ATTR(NA)) i_vaf_fetch_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vtx_idx_i(vtx), .desc_i(desc),
    .pack_i(pack), .base_i(base_v), .stride_i(stride_v),
    .av_valid_o(av_valid), .av_ready_i(av_ready), .av_addr_o(av_addr),
    .av_attr_o(av_attr), .av_comp_o(av_comp), .av_fmt_o(av_fmt), .av_esize_o(av_esize),
    .dflt_valid_o(dflt_valid), .dflt_attr_o(dflt_attr), .done_o(done));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int esz(input int f);
    return (f == 3) ? 4 : (f == 2) ? 2 : 1;
  endfunction

  function automatic logic [63:0] fld(input int a, input int f, input int n);
    return (64'(f) << (4*a)) | (64'(n-1) << (4*a+2));
  endfunction

  // driver side of the scoreboard: predict the whole vertex
  task automatic predict(input logic [63:0] d, input logic [15:0] v, input logic [11:0] p);
    int          total;
    logic [31:0] b, prev_b;
    int          prev_bytes;
    prev_b = 0;
    prev_bytes = 0;
    total = int'(d[63:60]) + 1;
    for (int a = 0; a < total; a++) begin
      item_t it;
      int    f, n;
      bit    ch, dfl;
      f = 0; n = 1; ch = 1'b0;
      if (a < 12) begin
        f = int'(d[4*a +: 2]);
        n = int'(d[4*a+2 +: 2]) + 1;
        ch = (a > 0) && p[a];
        b = ch ? prev_b + 32'(prev_bytes) : base_v[a*32 +: 32];
        prev_b = b;
        prev_bytes = n * esz(f);
      end else begin
        b = base_v[a*32 +: 32];
      end
      dfl = (a >= 12) || d[48+a];
      if (dfl) begin
        it = '{kind: 1, attr: a, comp: 0, fmt: 0, es: 0, addr: 0, chained: 1'b0};
        q.push_back(it);
      end else begin
        for (int c = 0; c < n; c++) begin
          it = '{kind: 0, attr: a, comp: c, fmt: f, es: esz(f),
                 addr: b + stride_v[a*32 +: 32] * 32'(v) + 32'(c * esz(f)), chained: ch};
          q.push_back(it);
        end
      end
    end
    q.push_back('{kind: 2, attr: 0, comp: 0, fmt: 0, es: 0, addr: 0, chained: 1'b0});
  endtask

  // ready pattern, changed shortly after each edge
  always @(posedge clk) begin
    #1 av_ready <= rnd_ready ? ($urandom_range(2) != 0) : 1'b1;
  end

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (mon_en) begin
      if (stall_prev) begin
        check(av_valid && av_addr == p_addr && av_attr == p_attr && av_comp == p_comp,
              "R7", "stalled item moved", av_addr, p_addr);
      end
      stall_prev = av_valid && !av_ready;
      p_addr = av_addr; p_attr = av_attr; p_comp = av_comp;

      if (av_valid && av_ready) begin
        if (q.size() == 0) begin
          unexp++;
          check(1'b0, "R9", "unexpected address", av_addr, 0);
        end else begin
          item_t e;
          e = q.pop_front();
          check(e.kind == 0, "R4", "address where default or done due", 32'(e.kind), 0);
          check(av_attr == 4'(e.attr) && av_comp == 2'(e.comp), "R3", "attr/comp order",
                {av_attr, av_comp}, {4'(e.attr), 2'(e.comp)});
          check(av_fmt == 2'(e.fmt), "R1", "format code", av_fmt, e.fmt);
          check(av_esize == 3'(e.es), "R2", "element size", av_esize, e.es);
          if (e.chained) check(av_addr == e.addr, "R6", "chained address", av_addr, e.addr);
          else           check(av_addr == e.addr, "R5", "address", av_addr, e.addr);
        end
      end
      if (dflt_valid) begin
        if (q.size() == 0) begin
          unexp++;
          check(1'b0, "R9", "unexpected default", dflt_attr, 0);
        end else begin
          item_t e;
          e = q.pop_front();
          check(e.kind == 1 && dflt_attr == 4'(e.attr), "R4", "default select",
                dflt_attr, e.attr);
        end
      end
      if (done) begin
        if (q.size() == 0) begin
          unexp++;
          check(1'b0, "R9", "unexpected done", 1, 0);
        end else begin
          item_t e;
          e = q.pop_front();
          check(e.kind == 2, "R8", "done before last item", 32'(e.kind), 2);
          check(item_prev, "R8", "done not right after last item", 0, 1);
        end
      end
      item_prev = (av_valid && av_ready) || dflt_valid;
    end
  end

  task automatic run_vertex(input logic [63:0] d, input logic [15:0] v,
                            input logic [11:0] p, input bit poke, input string tag);
    int u0;
    u0 = unexp;
    predict(d, v, p);
    @(posedge clk); #1;
    desc = d; vtx = v; pack = p; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (poke) begin
      @(posedge clk); #1;
      vtx = v + 16'd3; desc = d ^ 64'h0000_0000_0000_0ff0; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    do @(negedge clk); while (!done);
    if (poke) begin
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    repeat (8) @(posedge clk);
    check(q.size() == 0 && unexp == u0, "R9", {tag, " stream not closed cleanly"},
          32'(q.size()), 0);
    q.delete();
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    rst_n = 1'b0; start = 1'b0; vtx = '0; desc = '0; pack = '0; av_ready = 1'b1;
    for (int k = 0; k < NA; k++) begin
      base_v[k*32 +: 32]   = 32'h1000_0000 + 32'(k) * 32'h0001_0000;
      stride_v[k*32 +: 32] = 32'h10 + 32'(k) * 32'h4;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!av_valid && !dflt_valid && !done, "R10", "outputs after reset",
          {av_valid, dflt_valid, done}, 0);
    mon_en = 1'b1;

    // three plain attributes, always ready
    d = fld(0, 3, 3) | fld(1, 1, 4) | fld(2, 2, 2) | (64'd2 << 60);
    run_vertex(d, 16'd5, 12'h000, 1'b0, "R1 R2 R5");

    // chained attributes sharing one buffer, stalling consumer
    rnd_ready = 1'b1;
    d = fld(0, 2, 3) | fld(1, 0, 4) | fld(2, 3, 1) | fld(3, 1, 2) | (64'd3 << 60);
    run_vertex(d, 16'd7, 12'b0000_0000_0111, 1'b0, "R6 R7");

    // full sixteen attributes with masked ones and a chain across a masked one
    d = 64'd15 << 60;
    for (int a = 0; a < 12; a++) d |= fld(a, a % 4, 1 + (a % 2));
    d |= 64'h022 << 48;
    run_vertex(d, 16'd2, 12'b0000_0100_0100, 1'b0, "R4");

    // start requests while busy and in the done cycle
    rnd_ready = 1'b0;
    d = fld(0, 1, 2) | fld(1, 3, 4) | (64'd1 << 60);
    run_vertex(d, 16'd9, 12'h000, 1'b1, "R9");

    // single byte attribute at the largest vertex index
    run_vertex(fld(0, 0, 1), 16'hFFFF, 12'h001, 1'b0, "R5 R6");

    // lone attribute that is masked to its default
    run_vertex(fld(0, 3, 4) | (64'h001 << 48), 16'd1, 12'h000, 1'b0, "R4 R8");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule